// File: doc/BRIEF.md
# Masked Level-Interrupt Aggregator with Acknowledge Decode

This block gathers twenty-two active-low, level-sensitive event inputs into a captured state word. It masks them with a software-written enable word and drives one interrupt request toward a host controller that reacts only to rising edges. Software reads the state, pending and enable words through a small synchronous register port. It writes the enables, a clear word for the internally latched bus-error condition, and a control word holding an acknowledge-mode bit.

The host line responds only to edges, so a condition that stays pending across a mask change or an acknowledge would never be seen again by the host. To prevent this, the block drops the request line for one clock after every enable write and every successful acknowledge. If anything enabled is still pending, the line then rises again. While the acknowledge-mode bit is set, every read is an interrupt-acknowledge. The read address selects a bus level from 1 to 7. The block signals the interrupter for that level, and the read returns the interrupter's status/ID byte. A read for a level that is not active, or for level 0, returns an error flag instead of data.

Top module: `lvl_irq_agg`

## Requirements
- R1: After a synchronous reset the enable word and the acknowledge-mode bit are zero and `host_irq_o` is low. With all event inputs high, the state word reads all ones.
- R2: State bit i equals `evt_n_i[i]` one clock after it is sampled. Bit 8 is also forced to 0 by the sticky bus-error flag. Reading the state word has no side effect, so two back-to-back reads return the same value.
- R3: The pending word equals the bitwise inverse of the state word ANDed with the enable word. When the enable word is all zeros, `host_irq_o` stays low.
- R4: With no enable write or acknowledge in the way, `host_irq_o` is high exactly when the pending word is nonzero. It follows a change on `evt_n_i` two clocks later.
- R5: Any enable write, issued at clock edge k, takes effect at edge k. `host_irq_o` is then low from edge k+1 to edge k+2 and is high again from k+2 if anything is pending, so every enable write yields a fresh rising edge.
- R6: An event that arrives while it is masked stays visible in the state word. Enabling it later produces a rising edge on `host_irq_o` two clocks after the write.
- R7: A one-clock `berr_pulse_i` drives state bit 8 to 0. Bit 8 stays 0 until a write to the clear register with data bit 8 set, and a clear write with bit 8 at 0 has no effect.
- R8: While control bit 0 is 1, a read whose address bits 3:1 hold a level n from 1 to 7 is an acknowledge when state bit n-1 is 0. During that cycle `iack_cyc_o` is high with `iack_lvl_o` = n, and the response carries `iack_id_i` zero-extended with the error flag low.
- R9: In acknowledge mode, a read of level 0, or of a level whose state bit is 1, returns data 0 with `rd_err_o` high. It leaves `iack_cyc_o` low and does not disturb `host_irq_o`.
- R10: A successful acknowledge forces `host_irq_o` low for one clock in the same way as R5, so conditions still pending raise a new edge.
- R11: Outside acknowledge mode, a read gives `rd_valid_o` one clock later. Address bits 3:1 select the word: 0 state, 1 pending, 2 enable, 3 clear (reads 0), 4 control (bit 0 is the acknowledge mode). Selects 5 to 7 read 0 without error. Source bits 0..6 are bus levels 1..7, bit 7 is the message condition, bit 8 is sticky bus error and bit 9 is the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_n_i | input | 22 | Active-low level event inputs |
| berr_pulse_i | input | 1 | One-clock bus-error pulse that sets the sticky condition |
| rd_en_i | input | 1 | Read request |
| wr_en_i | input | 1 | Write request |
| addr_i | input | 3 | Address bits 3:1: register select or acknowledge level |
| wr_data_i | input | 22 | Write data |
| rd_valid_o | output | 1 | Read response valid, one clock after the request |
| rd_data_o | output | 22 | Read response data |
| rd_err_o | output | 1 | Read response error (failed acknowledge) |
| iack_cyc_o | output | 1 | Acknowledge strobe toward the interrupter |
| iack_lvl_o | output | 3 | Level being acknowledged |
| iack_id_i | input | 8 | Status/ID byte from the interrupter |
| host_irq_o | output | 1 | Interrupt request to the edge-triggered host controller |

## Verification
The bench goes after the one-clock dip that follows enable writes and acknowledges. A design without it would leave the line high, so the host would lose every condition still pending. It enables a source that became active while masked and expects a late rising edge, which a design that only tracks new inputs would never give. It acknowledges levels 1, 3 and 4 and probes level 0 and an idle level, exposing off-by-one level decoding and a design that returns data for an inactive level. It also checks that the sticky bus error survives a clear write with the wrong bit, and that it is released by the right one.

// File: rtl/lia_pkg.sv
package lia_pkg;

    localparam int NUM_SRC  = 22;
    localparam int NUM_LVL  = 7;
    localparam int LVL_W    = 3;
    localparam int ID_W     = 8;
    localparam int MSG_BIT  = 7;
    localparam int BERR_BIT = 8;
    localparam int WDOG_BIT = 9;

    typedef enum logic [LVL_W-1:0] {
        SEL_STATE  = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_CLEAR  = 3'd3,
        SEL_CTRL   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic               valid;
        logic               err;
        logic [NUM_SRC-1:0] data;
    } rd_rsp_t;

    function automatic logic [NUM_SRC-1:0] zext_id(input logic [ID_W-1:0] id);
        logic [NUM_SRC-1:0] r;
        r = '0;
        r[ID_W-1:0] = id;
        return r;
    endfunction

endpackage

// File: rtl/lia_src_capture.sv
module lia_src_capture #(
    parameter int N          = lia_pkg::NUM_SRC,
    parameter int STICKY_IDX = lia_pkg::BERR_BIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_n_i,
    input  logic         berr_pulse_i,
    input  logic         sticky_clr_i,
    output logic [N-1:0] state_o
);

    logic [N-1:0] raw_q;
    logic         sticky_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q      <= '1;
            sticky_n_q <= 1'b1;
        end else begin
            raw_q <= raw_n_i;
            if (berr_pulse_i)
                sticky_n_q <= 1'b0;
            else if (sticky_clr_i)
                sticky_n_q <= 1'b1;
        end
    end

    always_comb begin
        state_o             = raw_q;
        state_o[STICKY_IDX] = raw_q[STICKY_IDX] & sticky_n_q;
    end

    // R7: a bus-error pulse leaves the sticky condition active
    p_sticky_set_r7: assert property (@(posedge clk) disable iff (rst)
        berr_pulse_i |=> !state_o[STICKY_IDX]);

    // R7: the sticky condition holds until a clear
    p_sticky_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!sticky_n_q && !sticky_clr_i) |=> !sticky_n_q);

endmodule

// File: rtl/lia_iack_dec.sv
module lia_iack_dec #(
    parameter int N       = lia_pkg::NUM_SRC,
    parameter int NUM_LVL = lia_pkg::NUM_LVL,
    parameter int LVL_W   = lia_pkg::LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iack_mode_i,
    input  logic             rd_en_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [N-1:0]     state_i,
    output logic             cyc_o,
    output logic             err_o
);

    localparam int NUM_CODES = 2 ** LVL_W;

    logic [NUM_CODES-1:0] lvl_act;

    assign lvl_act[0] = 1'b0;

    for (genvar g = 1; g < NUM_CODES; g++) begin : g_lvl
        if (g <= NUM_LVL) begin : g_real
            assign lvl_act[g] = ~state_i[g-1];
        end else begin : g_none
            assign lvl_act[g] = 1'b0;
        end
    end

    logic iack_rd;
    assign iack_rd = iack_mode_i & rd_en_i;
    assign cyc_o   = iack_rd &  lvl_act[lvl_i];
    assign err_o   = iack_rd & ~lvl_act[lvl_i];

    // R9: level 0 never reaches the interrupter
    p_no_lvl0_r9: assert property (@(posedge clk) disable iff (rst)
        cyc_o |-> (lvl_i != '0));

endmodule

// File: rtl/lia_irq_edge.sv
module lia_irq_edge #(
    parameter int N = lia_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pend_i,
    input  logic         kick_i,
    output logic         irq_o
);

    logic gap_q;
    logic irq_q;
    logic any_pend;

    assign any_pend = |pend_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            gap_q <= kick_i;
            irq_q <= any_pend & ~gap_q;
        end
    end

    assign irq_o = irq_q;

    // R5 / R10: every kick yields a low cycle on the request line
    p_gap_low_r5: assert property (@(posedge clk) disable iff (rst)
        kick_i |-> ##2 !irq_o);

    // R4: nothing pending means the line falls
    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !any_pend |=> !irq_o);

endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg #(
    parameter int N       = lia_pkg::NUM_SRC,
    parameter int LVL_W   = lia_pkg::LVL_W,
    parameter int ID_W    = lia_pkg::ID_W,
    parameter int NUM_LVL = lia_pkg::NUM_LVL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     evt_n_i,
    input  logic             berr_pulse_i,
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic [LVL_W-1:0] addr_i,
    input  logic [N-1:0]     wr_data_i,
    output logic             rd_valid_o,
    output logic [N-1:0]     rd_data_o,
    output logic             rd_err_o,
    output logic             iack_cyc_o,
    output logic [LVL_W-1:0] iack_lvl_o,
    input  logic [ID_W-1:0]  iack_id_i,
    output logic             host_irq_o
);
    import lia_pkg::*;

    localparam int STICKY_IDX = BERR_BIT;

    reg_sel_e     sel;
    logic [N-1:0] state_w;
    logic [N-1:0] pend_w;
    logic [N-1:0] en_q;
    logic         iack_mode_q;
    logic         sticky_clr;
    logic         iack_err;
    logic         kick;
    rd_rsp_t      rsp_q;
    logic [N-1:0] rd_mux;

    assign sel = reg_sel_e'(addr_i);

    lia_src_capture #(.N(N), .STICKY_IDX(STICKY_IDX)) u_cap (
        .clk          (clk),
        .rst          (rst),
        .raw_n_i      (evt_n_i),
        .berr_pulse_i (berr_pulse_i),
        .sticky_clr_i (sticky_clr),
        .state_o      (state_w)
    );

    lia_iack_dec #(.N(N), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_iack (
        .clk         (clk),
        .rst         (rst),
        .iack_mode_i (iack_mode_q),
        .rd_en_i     (rd_en_i),
        .lvl_i       (addr_i),
        .state_i     (state_w),
        .cyc_o       (iack_cyc_o),
        .err_o       (iack_err)
    );

    assign pend_w     = ~state_w & en_q;
    assign iack_lvl_o = addr_i;
    assign sticky_clr = wr_en_i && (sel == SEL_CLEAR) && wr_data_i[STICKY_IDX];
    assign kick       = (wr_en_i && (sel == SEL_ENABLE)) || iack_cyc_o;

    lia_irq_edge #(.N(N)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend_w),
        .kick_i (kick),
        .irq_o  (host_irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= '0;
            iack_mode_q <= 1'b0;
        end else if (wr_en_i) begin
            if (sel == SEL_ENABLE) en_q        <= wr_data_i;
            if (sel == SEL_CTRL)   iack_mode_q <= wr_data_i[0];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_STATE:  rd_mux = state_w;
            SEL_PEND:   rd_mux = pend_w;
            SEL_ENABLE: rd_mux = en_q;
            SEL_CTRL:   rd_mux[0] = iack_mode_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= rd_en_i;
            rsp_q.err   <= rd_en_i & iack_err;
            if (!rd_en_i)
                rsp_q.data <= '0;
            else if (iack_mode_q)
                rsp_q.data <= iack_cyc_o ? zext_id(iack_id_i) : '0;
            else
                rsp_q.data <= rd_mux;
        end
    end

    assign rd_valid_o = rsp_q.valid;
    assign rd_err_o   = rsp_q.err;
    assign rd_data_o  = rsp_q.data;

    // R1: reset leaves enables and acknowledge mode cleared, line low
    p_rst_clear_r1: assert property (@(posedge clk)
        rst |=> (en_q == '0 && !iack_mode_q && !host_irq_o));

    // R11: every read is answered one clock later
    p_rd_valid_r11: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> rd_valid_o);

    // R8: an acknowledge strobe is answered without error
    p_iack_ok_r8: assert property (@(posedge clk) disable iff (rst)
        iack_cyc_o |=> (rd_valid_o && !rd_err_o));

    // R9: an acknowledge read without a strobe answers with error
    p_iack_bad_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && iack_mode_q && !iack_cyc_o) |=> (rd_err_o && rd_data_o == '0));

    // R3: with everything masked the request line stays low
    p_masked_r3: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |=> !host_irq_o);

endmodule

// File: tb/test_lvl_irq_agg.sv
`timescale 1ns/1ps
module test_lvl_irq_agg;

    localparam int N = 22;

    typedef struct packed {
        logic [N-1:0] raw;
        logic [N-1:0] en;
        logic [N-1:0] pend;
        logic         irq;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{raw: 22'h3FFFFF, en: 22'h3FFFFF, pend: 22'h000000, irq: 1'b0},
        '{raw: 22'h3FFFFE, en: 22'h000001, pend: 22'h000001, irq: 1'b1},
        '{raw: 22'h3FFFFE, en: 22'h000002, pend: 22'h000000, irq: 1'b0},
        '{raw: 22'h2FFFFF, en: 22'h300000, pend: 22'h100000, irq: 1'b1},
        '{raw: 22'h000000, en: 22'h155555, pend: 22'h155555, irq: 1'b1},
        '{raw: 22'h3FFDFF, en: 22'h3FFDFF, pend: 22'h000000, irq: 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] evt_n;
    logic         berr_pulse;
    logic         rd_en, wr_en;
    logic [2:0]   addr;
    logic [N-1:0] wr_data;
    logic         rd_valid, rd_err, iack_cyc, host_irq;
    logic [N-1:0] rd_data;
    logic [2:0]   iack_lvl;
    logic [7:0]   iack_id;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    logic last_cyc;
    logic [2:0] last_lvl;

    always #2.5 clk = ~clk;

    // interrupter model: status/ID byte encodes the level
    assign iack_id = iack_cyc ? {5'b10110, iack_lvl} : 8'h00;

    lvl_irq_agg i_lvl_irq_agg (
        .clk          (clk),
        .rst          (rst),
        .evt_n_i      (evt_n),
        .berr_pulse_i (berr_pulse),
        .rd_en_i      (rd_en),
        .wr_en_i      (wr_en),
        .addr_i       (addr),
        .wr_data_i    (wr_data),
        .rd_valid_o   (rd_valid),
        .rd_data_o    (rd_data),
        .rd_err_o     (rd_err),
        .iack_cyc_o   (iack_cyc),
        .iack_lvl_o   (iack_lvl),
        .iack_id_i    (iack_id),
        .host_irq_o   (host_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [N-1:0] d);
        wr_en = 1'b1; addr = sel; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [N-1:0] d, output logic e);
        rd_en = 1'b1; addr = sel;
        #1;
        last_cyc = iack_cyc;
        last_lvl = iack_lvl;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        if (!rd_valid) begin
            checks++; errors++;
            $display("FAIL R11: actual rd_valid 0 expected 1");
        end
        d = rd_data;
        e = rd_err;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d;
        logic         e;
        logic [N-1:0] s1;

        rst = 1'b1; evt_n = '1; berr_pulse = 1'b0;
        rd_en = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        check("R1 irq", 32'(host_irq), 32'd0);
        rd(3'd2, d, e); check("R1 enable", 32'(d), 32'd0);
        rd(3'd4, d, e); check("R1 ctrl", 32'(d), 32'd0);
        rd(3'd0, d, e); check("R1 state", 32'(d), 32'h3FFFFF);

        // R2 R3 R4: vector table
        for (int i = 0; i < NVEC; i++) begin
            evt_n = VECS[i].raw;
            wr(3'd2, VECS[i].en);
            repeat (4) tick();
            rd(3'd0, d, e); check("R2 state vec", 32'(d), 32'(VECS[i].raw));
            rd(3'd1, d, e); check("R3 pending vec", 32'(d), 32'(VECS[i].pend));
            check("R4 irq vec", 32'(host_irq), 32'(VECS[i].irq));
        end
        evt_n = '1;
        wr(3'd2, '0);
        repeat (4) tick();

        // R4: input to line latency of two clocks
        evt_n = 22'h3FFFFE;
        wr(3'd2, 22'h000001);
        repeat (3) tick();
        check("R4 irq high", 32'(host_irq), 32'd1);

        // R5: enable write produces a one-clock dip
        wr(3'd2, 22'h000003);
        check("R5 before dip", 32'(host_irq), 32'd1);
        tick(); check("R5 dip", 32'(host_irq), 32'd0);
        tick(); check("R5 re-rise", 32'(host_irq), 32'd1);

        // R6: masked event stays pending, enabling raises an edge
        wr(3'd2, '0);
        repeat (3) tick();
        evt_n = 22'h3FFFF6;
        repeat (3) tick();
        check("R6 masked irq", 32'(host_irq), 32'd0);
        rd(3'd0, d, e); check("R6 state kept", 32'(d), 32'h3FFFF6);
        rd(3'd1, d, e); check("R6 pending masked", 32'(d), 32'd0);
        wr(3'd2, 22'h000008);
        check("R6 low after write", 32'(host_irq), 32'd0);
        tick(); check("R6 low gap", 32'(host_irq), 32'd0);
        tick(); check("R6 rise", 32'(host_irq), 32'd1);

        // R8: acknowledge level 3
        evt_n = 22'h3FFFF2;
        wr(3'd2, 22'h00000C);
        repeat (4) tick();
        wr(3'd4, 22'h000001);
        tick();
        rd(3'd3, d, e);
        check("R8 strobe", 32'(last_cyc), 32'd1);
        check("R8 level", 32'(last_lvl), 32'd3);
        check("R8 id", 32'(d), 32'h0000B3);
        check("R8 no err", 32'(e), 32'd0);
        // R10: acknowledge dip and re-rise
        tick(); check("R10 dip", 32'(host_irq), 32'd0);
        tick(); check("R10 re-rise", 32'(host_irq), 32'd1);

        rd(3'd1, d, e); check("R8 level1 id", 32'(d), 32'h0000B1);
        repeat (3) tick();
        rd(3'd4, d, e); check("R8 level4 id", 32'(d), 32'h0000B4);
        repeat (3) tick();

        // R9: inactive level and level 0
        rd(3'd5, d, e);
        check("R9 idle strobe", 32'(last_cyc), 32'd0);
        check("R9 idle err", 32'(e), 32'd1);
        check("R9 idle data", 32'(d), 32'd0);
        tick(); check("R9 irq kept", 32'(host_irq), 32'd1);
        tick(); check("R9 irq kept2", 32'(host_irq), 32'd1);
        rd(3'd0, d, e);
        check("R9 lvl0 err", 32'(e), 32'd1);
        check("R9 lvl0 data", 32'(d), 32'd0);

        // R11: register map outside acknowledge mode
        wr(3'd4, '0);
        rd(3'd4, d, e); check("R11 ctrl", 32'(d), 32'd0);
        rd(3'd5, d, e); check("R11 unused data", 32'(d), 32'd0);
        check("R11 unused err", 32'(e), 32'd0);
        rd(3'd2, d, e); check("R11 enable", 32'(d), 32'h00000C);
        rd(3'd3, d, e); check("R11 clear reads 0", 32'(d), 32'd0);

        // R7: sticky bus error
        berr_pulse = 1'b1; tick(); berr_pulse = 1'b0;
        tick();
        rd(3'd0, d, e); check("R7 set", 32'(d), 32'h3FFEF2);
        rd(3'd0, s1, e); check("R2 reread same", 32'(s1), 32'(d));
        wr(3'd3, 22'h000000);
        tick();
        rd(3'd0, d, e); check("R7 wrong clear ignored", 32'(d), 32'h3FFEF2);
        wr(3'd3, 22'h000100);
        tick();
        rd(3'd0, d, e); check("R7 cleared", 32'(d), 32'h3FFFF2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule